// File: doc/BRIEF.md
# Byte Register Bus Slave for a Serial Radio Controller

This block is the slave-side front end of a small serial radio controller. It sits on a 32-bit synchronous system bus and answers single byte transfers that a bus master starts by pulling both the select and the address strobe low. Each transfer carries a physical register address, a size code and a read/write flag. The block serves five byte-wide registers: a transmit byte, a transmit control/status byte, a receive byte, a receive control/status byte and a serial-configuration byte. Every transfer ends with a one-cycle acknowledge that uses the byte code of a three-wire, active-low acknowledge bus.

The transmit and receive shift datapaths sit outside the block. The block hands a written transmit byte to the transmitter with a one-cycle load pulse and sets a busy flag. The transmitter clears that flag with a done pulse. The receiver delivers a byte with a valid pulse, which sets a ready flag. Software sees both flags as the top bit of the matching control register.

Top module: `radio_bus_slave`

## Requirements
- R1: When the block is idle and samples `sel_n` and `strobe_n` both low at a clock edge, it drives `ack_n` to 3'b101 on the next cycle. Only line 1 is low. `lerr_n` stays high at all times.
- R2: The acknowledge lasts exactly one cycle. The block starts no new transfer until it has seen `strobe_n` high. A master that keeps `strobe_n` low after the acknowledge gets no second acknowledge.
- R3: The register addresses are: 0 transmit byte, 1 transmit control, 2 receive byte, 3 receive control, 4 serial configuration. A write takes its byte from `wdata[31:24]`. A read returns its byte on `rdata[31:24]` with `rdata[23:0]` zero.
- R4: A write to transmit control stores bits 6:0. Bit 6 drives `tx_enable`, so writing 0x40 raises it. A read returns {busy, stored bits 6:0}.
- R5: Busy is clear after reset. A byte write to address 0 pulses `tx_load` for one cycle with the byte on `tx_byte`, and sets busy. A `tx_done` pulse clears busy.
- R6: An `rx_valid` pulse stores `rx_byte` and sets ready, which is bit 7 of receive control. A read of address 2 returns the stored byte and clears ready. Receive control bits 6:0 are writable and read back.
- R7: The serial-configuration register is writable and readable, and its value appears on `serial_cfg`.
- R8: A write whose `size` is not 1 (byte) is acknowledged but changes no register.
- R9: Addresses 5 to 7 are acknowledged. Writes to them change nothing and reads return zero.
- R10: Synchronous active-high `rst` clears every register, busy and ready, returns `ack_n` to 3'b111 and clears `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low slave select |
| strobe_n | input | 1 | Active-low address strobe |
| size | input | 2 | Transfer size code, 1 = byte |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data, byte on bits 31:24 |
| rdata | output | 32 | Read data, byte on bits 31:24 |
| ack_n | output | 3 | Active-low acknowledge code |
| lerr_n | output | 1 | Active-low late error, always high |
| tx_enable | output | 1 | Transmitter enable, transmit control bit 6 |
| tx_byte | output | 8 | Byte held for the transmitter |
| tx_load | output | 1 | One-cycle pulse when a transmit byte is written |
| tx_done | input | 1 | Transmitter finished pulse, clears busy |
| rx_byte | input | 8 | Byte from the receiver |
| rx_valid | input | 1 | Receiver byte-valid pulse |
| serial_cfg | output | 8 | Serial configuration value |

## Verification
The assertions assume the master follows the bus protocol. It holds `sel_n`, `strobe_n`, `addr`, `rd`, `size` and `wdata` steady until it sees the acknowledge, and then raises the strobe before it raises the select. They also assume `rx_valid` and `tx_done` are single-cycle pulses. The bench drives every transfer through one task that follows this ordering. It changes inputs only on falling clock edges, and it raises the receiver and transmitter pulses between transfers. Random traffic picks addresses, data, directions and sizes under a fixed seed, and directed cases cover held strobes, non-byte writes, unused addresses and a reset in mid-run.

// File: rtl/radio_bus_pkg.sv
package radio_bus_pkg;

    localparam int ADDR_W = 3;
    localparam int ACK_W  = 3;

    localparam logic [ADDR_W-1:0] REG_TX_BYTE = 3'd0;
    localparam logic [ADDR_W-1:0] REG_TX_CTL  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_RX_BYTE = 3'd2;
    localparam logic [ADDR_W-1:0] REG_RX_CTL  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_SER_CFG = 3'd4;

    localparam logic [1:0]       SIZE_BYTE = 2'd1;
    localparam logic [ACK_W-1:0] ACK_BYTE  = 3'b101;
    localparam logic [ACK_W-1:0] ACK_IDLE  = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK,
        ST_HOLD
    } xfer_state_t;

    typedef struct packed {
        logic              take;
        logic              rd;
        logic              byte_sz;
        logic [ADDR_W-1:0] addr;
    } xfer_t;

    function automatic logic is_write_to(xfer_t x, logic [ADDR_W-1:0] a);
        return x.take && !x.rd && x.byte_sz && (x.addr == a);
    endfunction

    function automatic logic is_read_of(xfer_t x, logic [ADDR_W-1:0] a);
        return x.take && x.rd && (x.addr == a);
    endfunction

endpackage

// File: rtl/rbs_decode.sv
module rbs_decode
    import radio_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              strobe_n,
    input  logic [1:0]        size,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output xfer_t             xfer,
    output logic [ACK_W-1:0]  ack_n
);

    xfer_state_t state, state_nx;
    logic start;

    assign start = (state == ST_IDLE) && !sel_n && !strobe_n;

    always_comb begin
        xfer.take    = start;
        xfer.rd      = rd;
        xfer.byte_sz = (size == SIZE_BYTE);
        xfer.addr    = addr;
    end

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start)    state_nx = ST_ACK;
            ST_ACK:                state_nx = ST_HOLD;
            ST_HOLD: if (strobe_n) state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign ack_n = (state == ST_ACK) ? ACK_BYTE : ACK_IDLE;

    assert_ack_code_R1: assert property (@(posedge clk) disable iff (rst)
        (ack_n == ACK_BYTE) || (ack_n == ACK_IDLE));
    assert_ack_prompt_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> (ack_n == ACK_BYTE));
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
        (ack_n == ACK_BYTE) |=> (ack_n == ACK_IDLE));

endmodule

// File: rtl/rbs_regs.sv
module rbs_regs
    import radio_bus_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xfer,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-2:0] tx_cfg,
    output logic [BYTE_W-2:0] rx_cfg,
    output logic [BYTE_W-1:0] ser_cfg,
    output logic [BYTE_W-1:0] tx_hold,
    output logic [BYTE_W-1:0] rx_hold,
    output logic              busy,
    output logic              ready,
    output logic              tx_load
);

    logic wr_tx, wr_txc, wr_rxc, wr_ser, rd_rx;

    assign wr_tx  = is_write_to(xfer, REG_TX_BYTE);
    assign wr_txc = is_write_to(xfer, REG_TX_CTL);
    assign wr_rxc = is_write_to(xfer, REG_RX_CTL);
    assign wr_ser = is_write_to(xfer, REG_SER_CFG);
    assign rd_rx  = is_read_of(xfer, REG_RX_BYTE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_cfg  <= '0;
            rx_cfg  <= '0;
            ser_cfg <= '0;
            tx_hold <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= wr_tx;
            if (wr_tx)  tx_hold <= wbyte;
            if (wr_txc) tx_cfg  <= wbyte[BYTE_W-2:0];
            if (wr_rxc) rx_cfg  <= wbyte[BYTE_W-2:0];
            if (wr_ser) ser_cfg <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          busy <= 1'b0;
        else if (wr_tx)   busy <= 1'b1;
        else if (tx_done) busy <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready   <= 1'b0;
            rx_hold <= '0;
        end else if (rx_valid) begin
            ready   <= 1'b1;
            rx_hold <= rx_byte;
        end else if (rd_rx) begin
            ready   <= 1'b0;
        end
    end

    assert_busy_set_R5: assert property (@(posedge clk) disable iff (rst)
        wr_tx |=> (busy && tx_load));
    assert_ready_set_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> ready);
    assert_load_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

endmodule

// File: rtl/rbs_readmux.sv
module rbs_readmux
    import radio_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xfer,
    input  logic [BYTE_W-2:0] tx_cfg,
    input  logic [BYTE_W-2:0] rx_cfg,
    input  logic [BYTE_W-1:0] ser_cfg,
    input  logic [BYTE_W-1:0] tx_hold,
    input  logic [BYTE_W-1:0] rx_hold,
    input  logic              busy,
    input  logic              ready,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - BYTE_W;

    logic [BYTE_W-1:0] sel_byte;

    always_comb begin
        case (xfer.addr)
            REG_TX_BYTE: sel_byte = tx_hold;
            REG_TX_CTL:  sel_byte = {busy, tx_cfg};
            REG_RX_BYTE: sel_byte = rx_hold;
            REG_RX_CTL:  sel_byte = {ready, rx_cfg};
            REG_SER_CFG: sel_byte = ser_cfg;
            default:     sel_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                     rdata <= '0;
        else if (xfer.take && xfer.rd) rdata <= {sel_byte, {PAD_W{1'b0}}};
    end

    assert_lane_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer.take && xfer.rd) |=> (rdata[PAD_W-1:0] == '0));

endmodule

// File: rtl/radio_bus_slave.sv
module radio_bus_slave
    import radio_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              strobe_n,
    input  logic [1:0]        size,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ACK_W-1:0]  ack_n,
    output logic              lerr_n,
    output logic              tx_enable,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_load,
    input  logic              tx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic [BYTE_W-1:0] serial_cfg
);

    xfer_t             xfer;
    logic [BYTE_W-2:0] tx_cfg, rx_cfg;
    logic [BYTE_W-1:0] rx_hold;
    logic              busy, ready;

    rbs_decode u_decode (
        .clk(clk), .rst(rst), .sel_n(sel_n), .strobe_n(strobe_n),
        .size(size), .rd(rd), .addr(addr), .xfer(xfer), .ack_n(ack_n)
    );

    rbs_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst(rst), .xfer(xfer),
        .wbyte(wdata[DATA_W-1 -: BYTE_W]),
        .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_cfg(tx_cfg), .rx_cfg(rx_cfg), .ser_cfg(serial_cfg),
        .tx_hold(tx_byte), .rx_hold(rx_hold), .busy(busy), .ready(ready),
        .tx_load(tx_load)
    );

    rbs_readmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_readmux (
        .clk(clk), .rst(rst), .xfer(xfer), .tx_cfg(tx_cfg), .rx_cfg(rx_cfg),
        .ser_cfg(serial_cfg), .tx_hold(tx_byte), .rx_hold(rx_hold),
        .busy(busy), .ready(ready), .rdata(rdata)
    );

    assign lerr_n    = 1'b1;
    assign tx_enable = tx_cfg[BYTE_W-2];

endmodule

// File: tb/radio_bus_slave_test.sv
module radio_bus_slave_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, strobe_n = 1'b1, rd = 1'b1;
    logic [1:0]  size = 2'd0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [2:0]  ack_n;
    logic        lerr_n, tx_enable, tx_load;
    logic [7:0]  tx_byte, serial_cfg;
    logic        tx_done = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'd0;

    int checks = 0, errors = 0, loads = 0, cycles = 0;
    logic [7:0] last_load;
    logic [7:0] m_txc, m_rxc, m_ser, m_txb, m_rxb;
    logic       m_busy, m_ready;

    radio_bus_slave uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .strobe_n(strobe_n), .size(size),
        .rd(rd), .addr(addr), .wdata(wdata), .rdata(rdata), .ack_n(ack_n),
        .lerr_n(lerr_n), .tx_enable(tx_enable), .tx_byte(tx_byte),
        .tx_load(tx_load), .tx_done(tx_done), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .serial_cfg(serial_cfg)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        cycles++;
        if (tx_load) begin loads++; last_load = tx_byte; end
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_txb;
            3'd1: return {m_busy, m_txc[6:0]};
            3'd2: return m_rxb;
            3'd3: return {m_ready, m_rxc[6:0]};
            3'd4: return m_ser;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [2:0] a, input logic [1:0] sz,
                                        input logic [7:0] d);
        if (sz != 2'd1) return;
        case (a)
            3'd0: begin m_txb = d; m_busy = 1'b1; end
            3'd1: m_txc = {1'b0, d[6:0]};
            3'd3: m_rxc = {1'b0, d[6:0]};
            3'd4: m_ser = d;
            default: ;
        endcase
    endfunction

    function automatic void model_reset();
        m_txc = 0; m_rxc = 0; m_ser = 0; m_txb = 0; m_rxb = 0;
        m_busy = 0; m_ready = 0;
    endfunction

    // one bus transfer; hold = extra cycles the strobe is kept low after ack
    task automatic xfer(input logic r, input logic [2:0] a, input logic [1:0] sz,
                        input logic [7:0] d, input int hold, output logic [7:0] rb);
        int n = 0;
        rd = r; addr = a; size = sz; wdata = {d, 24'h5A5A5A};
        sel_n = 1'b0; strobe_n = 1'b0;
        @(negedge clk);
        while (ack_n != 3'b101 && n < 8) begin
            @(negedge clk); n++;
        end
        check(ack_n == 3'b101 && n == 0, "R1 ack code/latency", {29'd0, ack_n}, 3'b101);
        check(lerr_n == 1'b1, "R1 lerr_n high", lerr_n, 1);
        rb = rdata[31:24];
        if (r) check(rdata[23:0] == 24'd0, "R3 low lanes zero", rdata[23:0], 0);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(ack_n == 3'b111, "R2 no ack while strobe held", {29'd0, ack_n}, 3'b111);
        end
        strobe_n = 1'b1;
        @(negedge clk);
        check(ack_n == 3'b111, "R2 ack one cycle", {29'd0, ack_n}, 3'b111);
        sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_check(input logic [2:0] a, input string req);
        logic [7:0] got, exp;
        exp = model_read(a);
        xfer(1'b1, a, 2'd1, 8'h00, 0, got);
        check(got == exp, req, got, exp);
        if (a == 3'd2) m_ready = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] sz, input logic [7:0] d);
        logic [7:0] dummy;
        xfer(1'b0, a, sz, d, 0, dummy);
        model_write(a, sz, d);
    endtask

    task automatic rx_push(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        m_rxb = b; m_ready = 1'b1;
    endtask

    task automatic tx_finish();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        m_busy = 1'b0;
    endtask

    initial begin
        logic [7:0] got;
        int seed;
        seed = $urandom(32'h1234);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(ack_n == 3'b111, "R10 ack idle after reset", ack_n, 3'b111);
        check(rdata == 32'd0, "R10 rdata clear", rdata, 0);
        check(tx_enable == 1'b0, "R10 tx_enable clear", tx_enable, 0);
        rd_check(3'd1, "R5 busy clear after reset");

        // R4 transmit enable
        wr(3'd1, 2'd1, 8'h40);
        check(tx_enable == 1'b1, "R4 tx_enable set by 0x40", tx_enable, 1);
        rd_check(3'd1, "R4 tx control readback");
        wr(3'd1, 2'd1, 8'hFF);
        rd_check(3'd1, "R4 busy bit not writable");
        wr(3'd1, 2'd1, 8'h40);

        // R5 busy and load
        wr(3'd0, 2'd1, 8'h55);
        check(loads == 1 && last_load == 8'h55, "R5 tx_load with byte", last_load, 8'h55);
        rd_check(3'd1, "R5 busy set after tx write");
        rd_check(3'd0, "R3 tx byte readback");
        tx_finish();
        rd_check(3'd1, "R5 busy cleared by tx_done");

        // R6 receive
        rd_check(3'd3, "R6 ready clear before byte");
        rx_push(8'hA5);
        rd_check(3'd3, "R6 ready set");
        rd_check(3'd2, "R6 receive byte");
        rd_check(3'd3, "R6 ready cleared by read");
        wr(3'd3, 2'd1, 8'h32);
        rd_check(3'd3, "R6 receive control readback");

        // R7 serial config
        wr(3'd4, 2'd1, 8'h0A);
        check(serial_cfg == 8'h0A, "R7 serial_cfg output", serial_cfg, 8'h0A);
        rd_check(3'd4, "R7 serial config readback");

        // R8 non-byte size
        wr(3'd4, 2'd2, 8'hEE);
        rd_check(3'd4, "R8 word write ignored");
        wr(3'd0, 2'd0, 8'h99);
        check(loads == 1, "R8 no tx_load on non-byte write", loads, 1);

        // R9 unused addresses
        wr(3'd5, 2'd1, 8'h77);
        rd_check(3'd5, "R9 addr 5 reads zero");
        rd_check(3'd7, "R9 addr 7 reads zero");
        rd_check(3'd4, "R9 write to 5 left config");

        // R2 strobe held low after ack
        xfer(1'b1, 3'd4, 2'd1, 8'h00, 4, got);
        check(got == m_ser, "R2 held-strobe read data", got, m_ser);

        // random traffic
        for (int i = 0; i < 120; i++) begin
            logic [2:0] a;
            logic [1:0] sz;
            logic [7:0] d;
            int op;
            op = $urandom_range(0, 5);
            a  = 3'($urandom_range(0, 7));
            d  = 8'($urandom);
            sz = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd1;
            case (op)
                0, 1: wr(a, sz, d);
                2, 3: rd_check(a, "R3 random read");
                4:    rx_push(d);
                default: tx_finish();
            endcase
        end
        check(serial_cfg == m_ser, "R7 serial_cfg after random", serial_cfg, m_ser);
        check(tx_enable == m_txc[6], "R4 tx_enable after random", tx_enable, m_txc[6]);

        // R10 reset in mid-run
        wr(3'd4, 2'd1, 8'h3C);
        rx_push(8'h11);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        check(serial_cfg == 8'h00, "R10 serial config cleared", serial_cfg, 0);
        rd_check(3'd3, "R10 ready cleared");
        rd_check(3'd1, "R10 tx control cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule